// File: doc/BRIEF.md
# Bidirectional Printer Port Controller

This block is a parallel printer port placed behind a small processor register interface. The processor writes a data latch that drives an 8-bit data port. It writes a control register whose bits drive the four active-low handshake lines to the printer and set the data port's direction. It reads back the data pins, the control register and a status register. The status register collects the printer's busy, acknowledge, paper-out, online and error lines, plus a latched acknowledge event.

An interrupt output is produced from one of two sources, chosen by a strap input. With the strap low, the output follows the registered acknowledge line. With the strap high, it shows a flag that is latched on each acknowledge rising edge and cleared when the processor reads the status register. A bus-buffer enable is raised for as long as a read of this port is in progress, so that an external data-bus transceiver can be steered.

The four control lines are open drain. Each is modelled as a level output that is either pulled low or released (high).

Top module: `lpt_port`

## Requirements
- R1: While reset is asserted, and after it is released, the four control lines (strobe_n, autofd_n, init_n, selin_n) read 1 (released), data_out is 0, data_oe is 1 (drive), irq is 0 and the acknowledge flag is clear.
- R2: A write (cs_n=0, wr_n=0) to address 0 loads wdata into data_out at the next clock edge. A write strobe with cs_n=1 leaves every register unchanged.
- R3: A write to address 2 stores control bits [3:0], and each line is the inverse of its bit from the next edge: bit0 drives strobe_n, bit1 autofd_n, bit2 init_n, bit3 selin_n. Bit 5 is the direction: 1 sets data_oe to 0 (input), 0 drives. Reading address 2 returns {2'b00, bit5, 1'b0, bits[3:0]}.
- R4: Reading address 0 returns the current data_in pin values.
- R5: Reading address 1 returns {~busy, ack, pe, slct, err_n, flag, 2'b00}, with bit 7 as the most significant bit.
- R6: A rising edge of ack (high at a clock edge, low at the edge before) sets the flag at that edge. A set on the same edge as a status read wins.
- R7: A clock edge during a status read clears the flag, so the read that observes it returns bit 2 = 1 and the following read returns bit 2 = 0.
- R8: With irq_mode=1, irq equals the flag. With irq_mode=0, irq equals the value ack had at the previous clock edge.
- R9: bufen is 1 exactly while cs_n=0 and rd_n=0, with no clock delay.
- R10: Reading an unused address (3 to 7) returns 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cs_n | input | 1 | Port select, active low |
| addr | input | 3 | Register address |
| rd_n | input | 1 | Read strobe, active low |
| wr_n | input | 1 | Write strobe, active low |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data, combinational |
| bufen | output | 1 | Bus-buffer enable, high during a read |
| data_in | input | 8 | Sensed printer data pins |
| data_out | output | 8 | Printer data latch |
| data_oe | output | 1 | 1 = data port drives |
| ack | input | 1 | Printer acknowledge level |
| busy | input | 1 | Printer busy, high = not ready |
| pe | input | 1 | Paper-out |
| slct | input | 1 | Printer online |
| err_n | input | 1 | Printer error, low = error |
| irq_mode | input | 1 | Interrupt source strap |
| strobe_n | output | 1 | Data strobe line, 0 = pulled low |
| autofd_n | output | 1 | Autofeed line, 0 = pulled low |
| init_n | output | 1 | Initialize line, 0 = pulled low |
| selin_n | output | 1 | Select-in line, 0 = pulled low |
| irq | output | 1 | Interrupt output |

## Verification
Read data and bufen are combinational. They are due in the same cycle as the read strobes, and the bench samples them just before the closing edge, while the strobes are still held. Register writes, acknowledge-flag updates and the irq in both modes are due one clock edge after their cause. Each expected item carries the cycle in which it falls due, and the monitor compares it only in that cycle, halfway between edges. A status read is therefore judged before the edge that clears the flag, and the cleared value is judged after that edge.

// File: rtl/lpt_port.sv
module lpt_port #(
  parameter int DW = 8,
  parameter int AW = 3,
  parameter logic [AW-1:0] A_DATA = 'd0,
  parameter logic [AW-1:0] A_STAT = 'd1,
  parameter logic [AW-1:0] A_CTRL = 'd2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cs_n,
  input  logic [AW-1:0] addr,
  input  logic          rd_n,
  input  logic          wr_n,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] rdata,
  output logic          bufen,
  input  logic [DW-1:0] data_in,
  output logic [DW-1:0] data_out,
  output logic          data_oe,
  input  logic          ack,
  input  logic          busy,
  input  logic          pe,
  input  logic          slct,
  input  logic          err_n,
  input  logic          irq_mode,
  output logic          strobe_n,
  output logic          autofd_n,
  output logic          init_n,
  output logic          selin_n,
  output logic          irq
);
  localparam int DIR_BIT = 5;

  logic [3:0] ctl;
  logic       dir_in;
  logic       ack_q;
  logic       flag;

  wire rd_acc = !cs_n && !rd_n;
  wire wr_acc = !cs_n && !wr_n;
  wire ack_rise = ack && !ack_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      data_out <= '0;
      ctl      <= '0;
      dir_in   <= 1'b0;
      ack_q    <= 1'b0;
      flag     <= 1'b0;
    end else begin
      ack_q <= ack;
      if (wr_acc && addr == A_DATA) data_out <= wdata;
      if (wr_acc && addr == A_CTRL) begin
        ctl    <= wdata[3:0];
        dir_in <= wdata[DIR_BIT];
      end
      if (ack_rise) flag <= 1'b1;
      else if (rd_acc && addr == A_STAT) flag <= 1'b0;
    end
  end

  always_comb begin
    rdata = '0;
    if (rd_acc) begin
      unique case (addr)
        A_DATA:  rdata = data_in;
        A_STAT:  rdata = DW'({~busy, ack, pe, slct, err_n, flag, 2'b00});
        A_CTRL:  rdata = DW'({2'b00, dir_in, 1'b0, ctl});
        default: rdata = '0;
      endcase
    end
  end

  assign bufen    = rd_acc;
  assign data_oe  = !dir_in;
  assign strobe_n = !ctl[0];
  assign autofd_n = !ctl[1];
  assign init_n   = !ctl[2];
  assign selin_n  = !ctl[3];
  assign irq      = irq_mode ? flag : ack_q;
endmodule

// File: rtl/lpt_port_chk.sv
module lpt_port_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       cs_n,
  input logic [2:0] addr,
  input logic       rd_n,
  input logic       wr_n,
  input logic [7:0] wdata,
  input logic       bufen,
  input logic [7:0] data_out,
  input logic       ack,
  input logic       irq_mode,
  input logic       strobe_n,
  input logic       selin_n,
  input logic       irq
);
  a_r1_reset_released: assert property (@(posedge clk)
    !rst_n |=> (strobe_n && selin_n && !irq));

  a_r2_data_write: assert property (@(posedge clk) disable iff (!rst_n)
    (!cs_n && !wr_n && addr == 3'd0) |=> data_out == $past(wdata));

  a_r2_unselected_hold: assert property (@(posedge clk) disable iff (!rst_n)
    cs_n |=> $stable(data_out));

  a_r3_strobe_map: assert property (@(posedge clk) disable iff (!rst_n)
    (!cs_n && !wr_n && addr == 3'd2) |=> strobe_n == !$past(wdata[0]));

  a_r6_ack_edge_irq: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_mode && ack && !$past(ack)) |=> (irq || !irq_mode));

  a_r8_follow_ack: assert property (@(posedge clk) disable iff (!rst_n)
    (!irq_mode && $past(rst_n)) |-> irq == $past(ack));

  a_r9_bufen_on: assert property (@(posedge clk) disable iff (!rst_n)
    (!cs_n && !rd_n) |-> bufen);

  a_r9_bufen_off: assert property (@(posedge clk) disable iff (!rst_n)
    (cs_n || rd_n) |-> !bufen);
endmodule

bind lpt_port lpt_port_chk u_chk (
  .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .addr(addr), .rd_n(rd_n),
  .wr_n(wr_n), .wdata(wdata), .bufen(bufen), .data_out(data_out),
  .ack(ack), .irq_mode(irq_mode), .strobe_n(strobe_n),
  .selin_n(selin_n), .irq(irq)
);

// File: tb/sim_lpt_port.sv
module sim_lpt_port;
  logic clk = 0, rst_n = 0, cs_n = 1, rd_n = 1, wr_n = 1;
  logic [2:0] addr = 0;
  logic [7:0] wdata = 0, data_in = 0;
  logic ack = 0, busy = 0, pe = 0, slct = 0, err_n = 1, irq_mode = 1;
  logic [7:0] rdata, data_out;
  logic bufen, data_oe, strobe_n, autofd_n, init_n, selin_n, irq;

  always #2 clk = ~clk;

  lpt_port u0 (.*);

  typedef struct { int id; logic [7:0] exp; string tag; int due; } item_t;
  item_t q[$];
  int cyc = 0, checks = 0, fails = 0;
  bit done = 0;

  always @(posedge clk) cyc <= cyc + 1;

  function automatic logic [7:0] obs(int id);
    case (id)
      0: return rdata;
      1: return data_out;
      2: return {7'd0, data_oe};
      3: return {7'd0, strobe_n};
      4: return {7'd0, autofd_n};
      5: return {7'd0, init_n};
      6: return {7'd0, selin_n};
      7: return {7'd0, irq};
      default: return {7'd0, bufen};
    endcase
  endfunction

  task automatic expect_at(int id, logic [7:0] v, string tag, int d);
    item_t it;
    it.id = id; it.exp = v; it.tag = tag; it.due = cyc + d;
    q.push_back(it);
  endtask

  always @(negedge clk) begin
    #1;
    for (int i = q.size() - 1; i >= 0; i--) begin
      if (q[i].due == cyc) begin
        checks++;
        if (obs(q[i].id) !== q[i].exp) begin
          fails++;
          $display("FAIL %s: signal %0d actual %h expected %h", q[i].tag, q[i].id, obs(q[i].id), q[i].exp);
        end
        q.delete(i);
      end
    end
  end

  task automatic wr(logic [2:0] a, logic [7:0] d, bit sel = 1);
    @(negedge clk); cs_n = !sel; wr_n = 0; addr = a; wdata = d;
    @(negedge clk); cs_n = 1; wr_n = 1;
  endtask

  task automatic rd(logic [2:0] a, logic [7:0] e, string tag);
    @(negedge clk); cs_n = 0; rd_n = 0; addr = a;
    expect_at(0, e, tag, 0);
    expect_at(8, 8'd1, "R9", 0);
    @(negedge clk); cs_n = 1; rd_n = 1;
    expect_at(8, 8'd0, "R9", 0);
  endtask

  task automatic lines(logic s, logic f, logic i, logic l, string tag);
    expect_at(3, {7'd0, s}, tag, 0);
    expect_at(4, {7'd0, f}, tag, 0);
    expect_at(5, {7'd0, i}, tag, 0);
    expect_at(6, {7'd0, l}, tag, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    lines(1, 1, 1, 1, "R1");
    expect_at(1, 8'h00, "R1", 0);
    expect_at(2, 8'h01, "R1", 0);
    expect_at(7, 8'h00, "R1", 0);
    @(negedge clk); rst_n = 1;
    @(negedge clk);
    lines(1, 1, 1, 1, "R1");

    wr(3'd0, 8'hA5);
    expect_at(1, 8'hA5, "R2", 0);
    wr(3'd0, 8'h3C, 0);
    expect_at(1, 8'hA5, "R2 unselected", 0);
    wr(3'd2, 8'h05, 0);
    lines(1, 1, 1, 1, "R2 unselected ctl");

    wr(3'd2, 8'h05);
    lines(0, 1, 0, 1, "R3");
    wr(3'd2, 8'h0A);
    lines(1, 0, 1, 0, "R3");
    rd(3'd2, 8'h0A, "R3 readback");
    wr(3'd2, 8'h20);
    lines(1, 1, 1, 1, "R3");
    expect_at(2, 8'h00, "R3 dir", 0);
    rd(3'd2, 8'h20, "R3 readback");

    data_in = 8'h3C;
    rd(3'd0, 8'h3C, "R4");
    data_in = 8'hC3;
    rd(3'd0, 8'hC3, "R4");

    busy = 1; err_n = 0; pe = 1; slct = 0;
    rd(3'd1, 8'h20, "R5");
    busy = 0; err_n = 1; pe = 0; slct = 1;
    rd(3'd1, 8'h98, "R5");
    rd(3'd3, 8'h00, "R10");
    rd(3'd7, 8'h00, "R10");

    irq_mode = 1;
    @(negedge clk); ack = 1;
    expect_at(7, 8'h00, "R6 before edge", 0);
    expect_at(7, 8'h01, "R6", 1);
    @(negedge clk); ack = 0;
    @(negedge clk);
    expect_at(7, 8'h01, "R8 flag held", 0);
    rd(3'd1, 8'h9C, "R6 status flag");
    expect_at(7, 8'h00, "R7 cleared", 0);
    rd(3'd1, 8'h98, "R7");

    irq_mode = 0;
    @(negedge clk); ack = 1;
    expect_at(7, 8'h00, "R8 follow", 0);
    expect_at(7, 8'h01, "R8 follow", 1);
    @(negedge clk); ack = 0;
    expect_at(7, 8'h00, "R8 follow", 1);
    @(negedge clk);
    rd(3'd1, 8'h9C, "R6 flag in follow mode");
    rd(3'd1, 8'h98, "R7");

    irq_mode = 1;
    @(negedge clk); ack = 1; cs_n = 0; rd_n = 0; addr = 3'd1;
    @(negedge clk); cs_n = 1; rd_n = 1; ack = 0;
    expect_at(7, 8'h01, "R6 set wins", 0);
    repeat (3) @(negedge clk);
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    #400000;
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule